// File: doc/BRIEF.md
# Memory Data Width Adapter

This block sits between a 32-bit application port and the data path of an external memory whose width can be 32, 16 or 8 bits, chosen at run time by a 2-bit code. On the write side it slices each application word into one, two or four memory beats, each with its own active-low byte enables. It raises the application's write-next strobe only when the final beat of a word has been taken. On the read side it gathers narrow beats and hands the application one full 32-bit word with a single valid pulse.

Request fields are rescaled to memory units on the way through. The address input counts 16-bit halfwords and comes out one bit wider. The length input counts 32-bit words and is multiplied by the beat ratio. Request and acknowledge pass straight through. The width code is latched when a request is accepted (request and acknowledge both high in the same cycle), and that latched width governs the beat slicing and packing until the next acceptance.

Top module: `mem_width_adapter`

## Requirements
- R1: While reset is asserted, and after it is released until the first read completes, `appRdValid` is 0 and `appRdData` is 0. `appWrNext` is 0 whenever `memWrNext` is 0.
- R2: `memReq` equals `appReq` and `appReqAck` equals `memReqAck` in the same cycle, with no register in either path.
- R3: `memAddr` (one bit wider than `appAddr`) is derived from the live `widthSel`. Code 00 gives `appAddr` shifted right by one, code 01 gives `appAddr` unchanged, and codes 10 and 11 give `appAddr` shifted left by one.
- R4: `memLen` (two bits wider than `appLen`) equals `appLen` times 1 for code 00, times 2 for code 01, and times 4 for codes 1x.
- R5: In 32-bit mode, `memWrData` equals `appWrData` and `memWrEnN` equals `appWrEnN`. Every `memWrNext` pulse produces an `appWrNext` pulse in the same cycle.
- R6: In 16-bit mode a word is sent as two beats. Beat 0 places bits 15:0 in `memWrData[15:0]` with enables `{2'b11, appWrEnN[1:0]}`. Beat 1 places bits 31:16 in `memWrData[15:0]` with enables `{2'b11, appWrEnN[3:2]}`. Bits 31:16 of `memWrData` are 0. `appWrNext` pulses only together with the `memWrNext` that consumes beat 1.
- R7: In 8-bit mode (code 10 or 11) a word is sent as four beats, least significant byte first. Beat k places byte k in `memWrData[7:0]` with enables `{3'b111, appWrEnN[k]}`, and the upper 24 bits are 0. `appWrNext` pulses only with the `memWrNext` that consumes beat 3.
- R8: Reads collect beats from the low bits of `memRdData` (all 32 bits, 16 bits or 8 bits by mode), with the first beat in the least significant position. One cycle after the `memRdValid` that completes a word, `appRdValid` is 1 for one cycle and `appRdData` holds the assembled word.
- R9: `appRdValid` is 0 in every cycle that does not follow a word-completing beat. `appRdData` does not change in such cycles, and bits above the beat width on `memRdData` are ignored.
- R10: The width used for slicing and packing is the code present at acceptance. Changing `widthSel` afterwards does not change the beat count of the transfer in progress.
- R11: Acceptance of a new request restarts both the write and the read beat positions at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| widthSel | input | 2 | Memory width code: 00 = 32, 01 = 16, 1x = 8 bits |
| appReq | input | 1 | Application request |
| appAddr | input | ADDR_W | Request address in 16-bit units |
| appLen | input | LEN_W | Request length in 32-bit words |
| appReqAck | output | 1 | Acknowledge to the application |
| memReq | output | 1 | Request toward the memory core |
| memAddr | output | ADDR_W+1 | Address in memory-width units |
| memLen | output | LEN_W+2 | Length in memory beats |
| memReqAck | input | 1 | Acknowledge from the memory core |
| appWrData | input | 32 | Write word |
| appWrEnN | input | 4 | Active-low byte enables of the write word |
| appWrNext | output | 1 | Current write word fully consumed |
| memWrData | output | 32 | Write beat, right-aligned |
| memWrEnN | output | 4 | Active-low enables of the beat |
| memWrNext | input | 1 | Memory side took the current beat |
| memRdData | input | 32 | Read beat, right-aligned |
| memRdValid | input | 1 | Read beat valid |
| appRdData | output | 32 | Assembled read word |
| appRdValid | output | 1 | Read word valid pulse |

## Verification
A wrong beat position or latched width shows up on `memWrData` and `memWrEnN` on the very next beat, because the wrong lane or enable pair is presented at once. A miscounted beat total moves `appWrNext` or `appRdValid` to the wrong pulse inside the same word, so the error appears within at most four beats. A width latched at the wrong moment shows up when `widthSel` is changed in the middle of a transfer: the beat count then shifts within a single word. Read assembly errors are visible as a misplaced byte or half in `appRdData`, one cycle after the word's final beat.

// File: rtl/mwa_pkg.sv
package mwa_pkg;

  localparam int APP_DW = 32;
  localparam int APP_BW = APP_DW / 8;

  typedef enum logic [1:0] {
    MODE_W32 = 2'd0,
    MODE_W16 = 2'd1,
    MODE_W8  = 2'd2
  } widthMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    widthMode_e mode;
    logic [1:0] wrBeat;
    logic [1:0] rdBeat;
    logic       rdCapture;
    logic       rdFinal;
  } ctrlBus_t;

  function automatic widthMode_e decodeWidth(input logic [1:0] code);
    case (code)
      2'b00:   return MODE_W32;
      2'b01:   return MODE_W16;
      default: return MODE_W8;
    endcase
  endfunction

  function automatic logic [1:0] lastBeatOf(input widthMode_e mode);
    case (mode)
      MODE_W32: return 2'd0;
      MODE_W16: return 2'd1;
      default:  return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/mwa_ctrl.sv
module mwa_ctrl
  import mwa_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        widthSel,
  input  logic              accept,
  input  logic [ADDR_W-1:0] appAddr,
  input  logic [LEN_W-1:0]  appLen,
  input  logic              memWrNext,
  input  logic              memRdValid,
  output logic [ADDR_W:0]   memAddr,
  output logic [LEN_W+1:0]  memLen,
  output logic              appWrNext,
  output ctrlBus_t          ctrlBus
);

  widthMode_e liveMode;
  widthMode_e lockMode;
  logic [1:0] wrBeat;
  logic [1:0] rdBeat;
  logic [1:0] lastIdx;
  logic       wrLast;
  logic       rdLast;

  assign liveMode = decodeWidth(widthSel);
  assign lastIdx  = lastBeatOf(lockMode);
  assign wrLast   = (wrBeat == lastIdx);
  assign rdLast   = (rdBeat == lastIdx);

  // Request rescaling follows the live width code
  always_comb begin
    case (liveMode)
      MODE_W32: begin
        memAddr = {2'b00, appAddr[ADDR_W-1:1]};
        memLen  = {2'b00, appLen};
      end
      MODE_W16: begin
        memAddr = {1'b0, appAddr};
        memLen  = {1'b0, appLen, 1'b0};
      end
      default: begin
        memAddr = {appAddr, 1'b0};
        memLen  = {appLen, 2'b00};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockMode <= MODE_W32;
      wrBeat   <= 2'd0;
      rdBeat   <= 2'd0;
    end else if (accept) begin
      lockMode <= liveMode;
      wrBeat   <= 2'd0;
      rdBeat   <= 2'd0;
    end else begin
      if (memWrNext) begin
        wrBeat <= wrLast ? 2'd0 : wrBeat + 2'd1;
      end
      if (memRdValid) begin
        rdBeat <= rdLast ? 2'd0 : rdBeat + 2'd1;
      end
    end
  end

  assign appWrNext = memWrNext && wrLast;

  always_comb begin
    ctrlBus.mode      = lockMode;
    ctrlBus.wrBeat    = wrBeat;
    ctrlBus.rdBeat    = rdBeat;
    ctrlBus.rdCapture = memRdValid;
    ctrlBus.rdFinal   = rdLast;
  end

endmodule

// File: rtl/mwa_datapath.sv
module mwa_datapath
  import mwa_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlBus_t          ctrlBus,
  input  logic [APP_DW-1:0] appWrData,
  input  logic [APP_BW-1:0] appWrEnN,
  input  logic [APP_DW-1:0] memRdData,
  output logic [APP_DW-1:0] memWrData,
  output logic [APP_BW-1:0] memWrEnN,
  output logic [APP_DW-1:0] appRdData,
  output logic              appRdValid
);

  localparam int HALF_W = APP_DW / 2;
  localparam int HALF_B = APP_BW / 2;

  logic [HALF_W-1:0] wrHalf;
  logic [HALF_B-1:0] wrHalfEn;
  logic [7:0]        wrByte;
  logic              wrByteEn;
  logic [APP_DW-1:0] rdBuf;
  logic [APP_DW-1:0] assembled;

  // Write lane selection
  assign wrHalf   = ctrlBus.wrBeat[0] ? appWrData[APP_DW-1:HALF_W] : appWrData[HALF_W-1:0];
  assign wrHalfEn = ctrlBus.wrBeat[0] ? appWrEnN[APP_BW-1:HALF_B] : appWrEnN[HALF_B-1:0];
  assign wrByte   = appWrData[{ctrlBus.wrBeat, 3'b000} +: 8];
  assign wrByteEn = appWrEnN[ctrlBus.wrBeat];

  always_comb begin
    case (ctrlBus.mode)
      MODE_W32: begin
        memWrData = appWrData;
        memWrEnN  = appWrEnN;
      end
      MODE_W16: begin
        memWrData = {{HALF_W{1'b0}}, wrHalf};
        memWrEnN  = {{HALF_B{1'b1}}, wrHalfEn};
      end
      default: begin
        memWrData = {{(APP_DW-8){1'b0}}, wrByte};
        memWrEnN  = {{(APP_BW-1){1'b1}}, wrByteEn};
      end
    endcase
  end

  // Read packing: drop the incoming beat into its slot
  always_comb begin
    assembled = rdBuf;
    case (ctrlBus.mode)
      MODE_W32: assembled = memRdData;
      MODE_W16: begin
        if (ctrlBus.rdBeat[0]) assembled[APP_DW-1:HALF_W] = memRdData[HALF_W-1:0];
        else                   assembled[HALF_W-1:0]      = memRdData[HALF_W-1:0];
      end
      default: assembled[{ctrlBus.rdBeat, 3'b000} +: 8] = memRdData[7:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdBuf      <= '0;
      appRdData  <= '0;
      appRdValid <= 1'b0;
    end else begin
      appRdValid <= ctrlBus.rdCapture && ctrlBus.rdFinal;
      if (ctrlBus.rdCapture) begin
        rdBuf <= assembled;
        if (ctrlBus.rdFinal) begin
          appRdData <= assembled;
        end
      end
    end
  end

endmodule

// File: rtl/mem_width_adapter.sv
module mem_width_adapter
  import mwa_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        widthSel,
  input  logic              appReq,
  input  logic [ADDR_W-1:0] appAddr,
  input  logic [LEN_W-1:0]  appLen,
  output logic              appReqAck,
  output logic              memReq,
  output logic [ADDR_W:0]   memAddr,
  output logic [LEN_W+1:0]  memLen,
  input  logic              memReqAck,
  input  logic [31:0]       appWrData,
  input  logic [3:0]        appWrEnN,
  output logic              appWrNext,
  output logic [31:0]       memWrData,
  output logic [3:0]        memWrEnN,
  input  logic              memWrNext,
  input  logic [31:0]       memRdData,
  input  logic              memRdValid,
  output logic [31:0]       appRdData,
  output logic              appRdValid
);

  ctrlBus_t ctrlBus;
  logic     accept;

  assign memReq    = appReq;
  assign appReqAck = memReqAck;
  assign accept    = appReq && memReqAck;

  mwa_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .widthSel  (widthSel),
    .accept    (accept),
    .appAddr   (appAddr),
    .appLen    (appLen),
    .memWrNext (memWrNext),
    .memRdValid(memRdValid),
    .memAddr   (memAddr),
    .memLen    (memLen),
    .appWrNext (appWrNext),
    .ctrlBus   (ctrlBus)
  );

  mwa_datapath u_data (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlBus   (ctrlBus),
    .appWrData (appWrData),
    .appWrEnN  (appWrEnN),
    .memRdData (memRdData),
    .memWrData (memWrData),
    .memWrEnN  (memWrEnN),
    .appRdData (appRdData),
    .appRdValid(appRdValid)
  );

endmodule

// File: rtl/mwa_checker.sv
module mwa_checker
  import mwa_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       appReq,
  input logic       memReqAck,
  input logic       appWrNext,
  input logic       memWrNext,
  input logic       appRdValid,
  input logic       memRdValid,
  input logic [31:0] appRdData,
  input logic [3:0] memWrEnN,
  input widthMode_e lockMode
);

  AST_RDVALID_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    appRdValid |-> $past(memRdValid)); // R8

  AST_WRNEXT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    appWrNext |-> memWrNext); // R6

  AST_HALF_ENABLES: assert property (@(posedge clk) disable iff (!rstN)
    (lockMode == MODE_W16) |-> (memWrEnN[3:2] == 2'b11)); // R6

  AST_BYTE_ENABLES: assert property (@(posedge clk) disable iff (!rstN)
    (lockMode == MODE_W8) |-> (memWrEnN[3:1] == 3'b111)); // R7

  AST_RDDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !appRdValid |-> $stable(appRdData)); // R9

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !$past(appReq && memReqAck) |-> $stable(lockMode)); // R10

endmodule

bind mem_width_adapter mwa_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .appReq    (appReq),
  .memReqAck (memReqAck),
  .appWrNext (appWrNext),
  .memWrNext (memWrNext),
  .appRdValid(appRdValid),
  .memRdValid(memRdValid),
  .appRdData (appRdData),
  .memWrEnN  (memWrEnN),
  .lockMode  (ctrlBus.mode)
);

// File: tb/sim_mem_width_adapter.sv
module sim_mem_width_adapter;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int LW = 9;

  logic          clk = 1'b0;
  logic          rstN;
  logic [1:0]    widthSel;
  logic          appReq;
  logic [AW-1:0] appAddr;
  logic [LW-1:0] appLen;
  logic          appReqAck;
  logic          memReq;
  logic [AW:0]   memAddr;
  logic [LW+1:0] memLen;
  logic          memReqAck;
  logic [31:0]   appWrData;
  logic [3:0]    appWrEnN;
  logic          appWrNext;
  logic [31:0]   memWrData;
  logic [3:0]    memWrEnN;
  logic          memWrNext;
  logic [31:0]   memRdData;
  logic          memRdValid;
  logic [31:0]   appRdData;
  logic          appRdValid;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_width_adapter #(.ADDR_W(AW), .LEN_W(LW)) u0 (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int beatsFor(input logic [1:0] code);
    return (code == 2'b00) ? 1 : (code == 2'b01) ? 2 : 4;
  endfunction

  task automatic tRequest(input logic [1:0] code, input logic [AW-1:0] addr, input logic [LW-1:0] len);
    logic [AW:0]   eAddr;
    logic [LW+1:0] eLen;
    @(negedge clk);
    widthSel = code; appAddr = addr; appLen = len; appReq = 1'b1; memReqAck = 1'b1;
    #1;
    if (code == 2'b00)      eAddr = {1'b0, addr} >> 1;
    else if (code == 2'b01) eAddr = {1'b0, addr};
    else                    eAddr = {addr, 1'b0};
    eLen = (LW+2)'(len) * (LW+2)'(beatsFor(code));
    check("R2 memReq", 64'(memReq), 64'd1);
    check("R2 appReqAck", 64'(appReqAck), 64'd1);
    check("R3 memAddr", 64'(memAddr), 64'(eAddr));
    check("R4 memLen", 64'(memLen), 64'(eLen));
    @(negedge clk);
    appReq = 1'b0; memReqAck = 1'b0;
    #1;
    check("R2 ack low", 64'(appReqAck), 64'd0);
  endtask

  // lockCode: width that was latched at acceptance
  task automatic tWriteWord(input logic [1:0] lockCode, input logic [31:0] data, input logic [3:0] en);
    int nb = beatsFor(lockCode);
    string tag = (lockCode == 2'b00) ? "R5" : (lockCode == 2'b01) ? "R6" : "R7";
    appWrData = data; appWrEnN = en;
    for (int b = 0; b < nb; b++) begin
      logic [31:0] eD;
      logic [3:0]  eE;
      if (nb == 1)      begin eD = data; eE = en; end
      else if (nb == 2) begin eD = (data >> (16*b)) & 32'hFFFF; eE = {2'b11, en[2*b +: 2]}; end
      else              begin eD = (data >> (8*b)) & 32'hFF; eE = {3'b111, en[b]}; end
      #1;
      check({tag, " memWrData"}, 64'(memWrData), 64'(eD));
      check({tag, " memWrEnN"}, 64'(memWrEnN), 64'(eE));
      check({tag, " R1 idle wrNext"}, 64'(appWrNext), 64'd0);
      memWrNext = 1'b1;
      #1;
      check({tag, " appWrNext"}, 64'(appWrNext), 64'(b == nb-1));
      @(negedge clk);
      memWrNext = 1'b0;
    end
  endtask

  task automatic tReadWord(input logic [1:0] lockCode, input logic [31:0] word);
    int nb = beatsFor(lockCode);
    logic [31:0] held;
    for (int b = 0; b < nb; b++) begin
      memRdValid = 1'b1;
      if (nb == 1)      memRdData = word;
      else if (nb == 2) memRdData = {16'hDEAD, word[16*b +: 16]};
      else              memRdData = {24'hC3C3C3, word[8*b +: 8]};
      held = appRdData;
      @(negedge clk);
      #1;
      if (b < nb-1) begin
        check("R9 no early valid", 64'(appRdValid), 64'd0);
        check("R9 data held", 64'(appRdData), 64'(held));
      end else begin
        check("R8 valid", 64'(appRdValid), 64'd1);
        check("R8 word", 64'(appRdData), 64'(word));
      end
    end
    memRdValid = 1'b0; memRdData = 32'h5A5A5A5A;
    @(negedge clk);
    #1;
    check("R9 valid drop", 64'(appRdValid), 64'd0);
    check("R9 hold after", 64'(appRdData), 64'(word));
  endtask

  task automatic tModeSwitch();
    tRequest(2'b01, 24'h000010, 9'd2);
    widthSel = 2'b00;
    tWriteWord(2'b01, 32'h55AA33CC, 4'b1100); // R10: still two beats
    widthSel = 2'b10;
    tReadWord(2'b01, 32'hFACE0BAD);           // R10
  endtask

  task automatic tRealign();
    tRequest(2'b10, 24'h000020, 9'd1);
    appWrData = 32'h01020304; appWrEnN = 4'b0000;
    memWrNext = 1'b1; memRdValid = 1'b1; memRdData = 32'h000000EE;
    @(negedge clk);
    memWrNext = 1'b0; memRdValid = 1'b0;
    tRequest(2'b01, 24'h000030, 9'd1);        // R11 restart at beat 0
    tWriteWord(2'b01, 32'h9988_7766, 4'b0011);
    tReadWord(2'b01, 32'h2468ACE0);
  endtask

  initial begin
    rstN = 1'b0; widthSel = 2'b00; appReq = 1'b0; appAddr = '0; appLen = '0;
    memReqAck = 1'b0; appWrData = '0; appWrEnN = 4'hF; memWrNext = 1'b0;
    memRdData = '0; memRdValid = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 rdValid reset", 64'(appRdValid), 64'd0);
    check("R1 rdData reset", 64'(appRdData), 64'd0);
    check("R1 wrNext reset", 64'(appWrNext), 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check("R1 rdValid after", 64'(appRdValid), 64'd0);

    tRequest(2'b00, 24'h000124, 9'd5);
    tWriteWord(2'b00, 32'h11223344, 4'b0101);
    tReadWord(2'b00, 32'hCAFEF00D);

    tRequest(2'b01, 24'h000124, 9'd5);
    tWriteWord(2'b01, 32'hA1B2C3D4, 4'b1001);
    tReadWord(2'b01, 32'h87654321);

    tRequest(2'b10, 24'hFFFFFF, 9'd511);
    tWriteWord(2'b10, 32'h0F1E2D3C, 4'b0110);
    tReadWord(2'b10, 32'h13579BDF);

    tRequest(2'b11, 24'h000003, 9'd7);
    tWriteWord(2'b11, 32'hDEADBEEF, 4'b1010);
    tReadWord(2'b11, 32'h0BADF00D);

    tModeSwitch();
    tRealign();

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule